// File: doc/BRIEF.md
# DMA Transfer-Request Staging Queue

This block follows transfer requests (TRs) through the staging part of a DMA transfer controller. A channel controller writes a TR into a single program slot. From there the TR moves into a destination-side circular queue that holds up to four entries. The rule for that move depends on how full the queue is and on whether the source engine is busy. The TR at the head of the queue leaves when its completion pulse arrives. A separate counter follows issued write commands until their write responses come back.

The block carries no TR payload, only occupancy and ordering state. It reports that state in a packed, read-only 32-bit status word, which a debugger or the controller can sample at any time. A one-cycle overrun pulse flags a TR write that the slot had to refuse.

Top module: `tr_stage_queue`

## Requirements
- R1: Queue occupancy reads in status bits 6:4 as a count from 0 to 4. Values 5 to 7 never appear.
- R2: While the program slot is busy and the queue is empty, the TR moves into the queue at the next clock edge, whatever the source engine reports.
- R3: While the slot is busy and the queue holds 1 to 3 TRs, the TR moves at a clock edge only if `src_busy_i` was 0 in that cycle. Otherwise it stays in the slot.
- R4: While the queue holds 4 TRs, no TR moves from the slot, and the slot stays busy.
- R5: A `head_done_i` pulse while the queue is non-empty retires the head, and occupancy drops by one at the next edge. A pulse while the queue is empty has no effect. A retire and a move in the same cycle leave occupancy unchanged.
- R6: Status bits 12:11 hold the head pointer. It advances by one, modulo 4, at every retire.
- R7: Status bit 0 (program busy) reads 1 from the edge after an accepted TR write until the edge at which that TR moves into the queue.
- R8: Status bit 2 reads 1 while the count of issued writes exceeds the count of responses. An issue and a response in the same cycle leave the count unchanged. A response at count 0 is ignored. An issue at the counter's maximum (7) is ignored.
- R9: Status bit 1 mirrors `src_busy_i` in the same cycle. Bit 8 always reads 1. Every bit not named in R1, R6, R7, R8 or R9 reads 0.
- R10: A TR write while the slot is busy is ignored. `overrun_o` is high for exactly the one cycle after that write.
- R11: After reset the queue is empty, the head pointer is 0, no writes are pending, and the status word reads 0x00000100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tr_wr_i | input | 1 | Channel controller writes a TR into the program slot |
| src_busy_i | input | 1 | Source engine is servicing a TR |
| head_done_i | input | 1 | TR at the queue head has completed |
| wr_issue_i | input | 1 | A write command was issued |
| wr_resp_i | input | 1 | A write response was received |
| status_o | output | 32 | Packed status word |
| overrun_o | output | 1 | Refused TR write, one cycle after it |

## Verification
Every state bit in the status word lags its cause by one register. An input driven in cycle n shows in the occupancy, head pointer, busy and pending fields after clock edge n+1, and the overrun pulse appears in that same following cycle. Status bit 1 is combinational from `src_busy_i`. The bench drives its inputs at the falling edge and advances a reference model on the rising edge. It compares every field shortly after that rising edge, so both the one-cycle results and the same-cycle mirror bit are read while the inputs are still stable.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  localparam int STATUS_W = 32;

  // Packs the status fields into the fixed word layout.
  function automatic logic [STATUS_W-1:0] pack_status(
    input logic       busy,
    input logic       src,
    input logic       pend,
    input logic [2:0] occ,
    input logic [1:0] ptr
  );
    logic [STATUS_W-1:0] s;
    s        = '0;
    s[0]     = busy;
    s[1]     = src;
    s[2]     = pend;
    s[6:4]   = occ;
    s[8]     = 1'b1;
    s[12:11] = ptr;
    return s;
  endfunction

  // Queue admission rule: an empty queue always accepts, a partly filled
  // queue accepts only while the source engine is idle, a full one never.
  function automatic logic may_enter(
    input logic empty,
    input logic full,
    input logic src_busy
  );
    return empty | (~full & ~src_busy);
  endfunction

endpackage

// File: rtl/tsq_prog_slot.sv
module tsq_prog_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic move_i,
  output logic busy_o,
  output logic accept_o,
  output logic overrun_o
);

  logic busy_q;
  logic ovr_q;
  logic reject;

  assign accept_o = wr_i & ~busy_q;
  assign reject   = wr_i & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= reject;
      if (accept_o)    busy_q <= 1'b1;
      else if (move_i) busy_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign overrun_o = ovr_q;

  p_move_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    move_i |-> busy_q);
  p_busy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    move_i |=> !busy_o);
  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);
  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(wr_i));
  p_ignored_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && busy_q && !move_i) |=> busy_o);

endmodule

// File: rtl/tsq_dst_queue.sv
module tsq_dst_queue #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             done_i,
  output logic [OCC_W-1:0] occ_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             retire_o
);

  logic [OCC_W-1:0] occ_q;
  logic [PTR_W-1:0] ptr_q;

  assign empty_o  = (occ_q == '0);
  assign full_o   = (occ_q == OCC_W'(DEPTH));
  assign retire_o = done_i & ~empty_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      ptr_q <= '0;
    end else begin
      if (push_i && !retire_o)      occ_q <= occ_q + 1'b1;
      else if (!push_i && retire_o) occ_q <= occ_q - 1'b1;
      if (retire_o) begin
        if (ptr_q == PTR_W'(DEPTH - 1)) ptr_q <= '0;
        else                            ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign occ_o = occ_q;
  assign ptr_o = ptr_q;

  p_occ_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o <= OCC_W'(DEPTH));
  p_push_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  p_empty_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && empty_o && !push_i) |=> (occ_o == '0));
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retire_o |=> (ptr_o != $past(ptr_o)));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_o |=> $stable(ptr_o));

endmodule

// File: rtl/tsq_wr_tracker.sv
module tsq_wr_tracker #(
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  input  logic resp_i,
  output logic pending_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             inc;
  logic             dec;

  assign inc = issue_i & ~resp_i & (cnt_q != CNT_MAX);
  assign dec = resp_i & ~issue_i & (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
    else if (dec) cnt_q <= cnt_q - 1'b1;
  end

  assign pending_o = (cnt_q != '0);

  p_same_cycle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && resp_i) |=> $stable(cnt_q));
  p_issue_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !resp_i) |=> pending_o);
  p_idle_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && resp_i && !issue_i) |=> !pending_o);

endmodule

// File: rtl/tr_stage_queue.sv
module tr_stage_queue #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tr_wr_i,
  input  logic        src_busy_i,
  input  logic        head_done_i,
  input  logic        wr_issue_i,
  input  logic        wr_resp_i,
  output logic [31:0] status_o,
  output logic        overrun_o
);
  import tsq_pkg::*;

  logic             prog_busy;
  logic             prog_accept;
  logic             move;
  logic [OCC_W-1:0] occ;
  logic [PTR_W-1:0] head_ptr;
  logic             q_empty;
  logic             q_full;
  logic             retire;
  logic             wr_pending;

  assign move = prog_busy & may_enter(q_empty, q_full, src_busy_i);

  tsq_prog_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (tr_wr_i),
    .move_i    (move),
    .busy_o    (prog_busy),
    .accept_o  (prog_accept),
    .overrun_o (overrun_o)
  );

  tsq_dst_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (move),
    .done_i   (head_done_i),
    .occ_o    (occ),
    .ptr_o    (head_ptr),
    .empty_o  (q_empty),
    .full_o   (q_full),
    .retire_o (retire)
  );

  tsq_wr_tracker #(.CNT_W(CNT_W)) u_wtrk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_i   (wr_issue_i),
    .resp_i    (wr_resp_i),
    .pending_o (wr_pending)
  );

  assign status_o = pack_status(prog_busy, src_busy_i, wr_pending,
                                3'(occ), 2'(head_ptr));

  p_empty_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && q_empty) |-> move);
  p_busy_src_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && !q_empty && src_busy_i) |=> prog_busy);
  p_full_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_busy && q_full) |=> prog_busy);
  p_const_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[8] && (status_o[31:13] == '0) && (status_o[10:9] == '0));
  p_accept_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_accept && move));

endmodule

// File: tb/tb_tr_stage_queue.sv
`timescale 1ns/1ps
module tb_tr_stage_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tr_wr_i = 0, src_busy_i = 0, head_done_i = 0;
  logic        wr_issue_i = 0, wr_resp_i = 0;
  logic [31:0] status_o;
  logic        overrun_o;

  int checks = 0;
  int errors = 0;

  // reference model
  int m_busy = 0, m_occ = 0, m_ptr = 0, m_cnt = 0, m_ovr = 0;

  always #2.5 clk = ~clk;

  tr_stage_queue dut (
    .clk(clk), .rst_n(rst_n), .tr_wr_i(tr_wr_i), .src_busy_i(src_busy_i),
    .head_done_i(head_done_i), .wr_issue_i(wr_issue_i), .wr_resp_i(wr_resp_i),
    .status_o(status_o), .overrun_o(overrun_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int rest;
    chk("R7 busy bit",       int'(status_o[0]), m_busy);
    chk("R9 src mirror",     int'(status_o[1]), int'(src_busy_i));
    chk("R8 pending bit",    int'(status_o[2]), (m_cnt != 0) ? 1 : 0);
    chk("R1 occupancy",      int'(status_o[6:4]), m_occ);
    chk("R6 head pointer",   int'(status_o[12:11]), m_ptr);
    rest = int'(status_o & 32'hFFFF_E688);
    chk("R9 reserved zero",  rest, 0);
    chk("R9 constant one",   int'(status_o[8]), 1);
    chk("R10 overrun pulse", int'(overrun_o), m_ovr);
  endtask

  // one cycle: inputs driven at negedge, model advances at posedge
  task automatic cyc(input logic wr, input logic sb, input logic dn,
                     input logic is, input logic rs);
    int mv, rt;
    tr_wr_i = wr; src_busy_i = sb; head_done_i = dn;
    wr_issue_i = is; wr_resp_i = rs;
    mv = (m_busy == 1 && (m_occ == 0 || (m_occ < 4 && !sb))) ? 1 : 0;
    rt = (dn && m_occ > 0) ? 1 : 0;
    @(posedge clk);
    m_ovr = (wr && m_busy == 1) ? 1 : 0;
    if (wr && m_busy == 0) m_busy = 1;
    else if (mv == 1)      m_busy = 0;
    m_occ = m_occ + mv - rt;
    if (rt == 1) m_ptr = (m_ptr + 1) % 4;
    if (is && !rs && m_cnt < 7) m_cnt++;
    else if (rs && !is && m_cnt > 0) m_cnt--;
    #1;
    check_all();
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R11 reset word", int'(status_o), 32'h100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset overrun", int'(overrun_o), 0);

    // R2: empty queue takes TR despite busy source
    cyc(1, 1, 0, 0, 0);
    chk("R2 slot busy", int'(status_o[0]), 1);
    cyc(0, 1, 0, 0, 0);
    chk("R2 moved with src busy", int'(status_o[6:4]), 1);
    // R3: partial queue blocked while source busy
    cyc(1, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    chk("R3 held while src busy", int'(status_o[0]), 1);
    // R10: write while busy
    cyc(1, 1, 0, 0, 0);
    chk("R10 overrun seen", int'(overrun_o), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R3 moved when idle", int'(status_o[6:4]), 2);
    // fill to 4 (R4)
    for (int i = 0; i < 2; i++) begin
      cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
    end
    chk("R1 full count", int'(status_o[6:4]), 4);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R4 blocked when full", int'(status_o[0]), 1);
    // R5: retire head then slot flows in
    cyc(0, 0, 1, 0, 0);
    chk("R5 retire", int'(status_o[6:4]), 3);
    chk("R6 ptr advanced", int'(status_o[12:11]), 1);
    cyc(0, 0, 0, 0, 0);
    chk("R4 flows after retire", int'(status_o[6:4]), 4);
    // drain, then done on empty ignored
    repeat (5) cyc(0, 0, 1, 0, 0);
    chk("R5 empty done ignored", int'(status_o[6:4]), 0);
    chk("R6 ptr wrapped", int'(status_o[12:11]), 1);
    // R8 counter: resp at zero, issue, both, saturation
    cyc(0, 0, 0, 0, 1);
    chk("R8 resp at zero", int'(status_o[2]), 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R8 both holds", int'(status_o[2]), 1);
    repeat (9) cyc(0, 0, 0, 1, 0);
    repeat (7) cyc(0, 0, 0, 0, 1);
    chk("R8 saturated then drained", int'(status_o[2]), 0);

    // near-exhaustive pseudo-random sweep over all input combinations
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr[1] & lfsr[7], lfsr[2] & lfsr[9], lfsr[3], lfsr[4] | lfsr[11]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule